// File: doc/BRIEF.md
# Five-Source Prioritized Interrupt Controller

This block sits beside an 8-bit processor core and decides which of five interrupt sources the core should service next. One source cannot be masked (the trap). Three are vectored lines, named 5.5, 6.5 and 7.5, and each has its own mask bit. The fifth is a request that carries no vector. The block holds a global enable flag, three mask flip-flops and a sticky edge latch for line 7.5. It also holds a serial output pin register.

The core writes a control byte to update the masks, clear the 7.5 latch and drive the serial output. It can read a status byte at any time. The core raises a check strobe when it is ready to take an interrupt. The block then holds the winning source code and its 16-bit vector until the core pulses acknowledge. Accepting a maskable source drops the global enable. The core turns the enable back on with a set command.

Top module: `vic_ctrl`

## Requirements
- R1: A synchronous reset sets all three masks to 1, clears the global enable, the 7.5 latch, the trap state, the serial output pin and the held request. With all inputs low, the status byte reads 0x07 one cycle after reset is released.
- R2: A control write with bit 3 set loads bits 0, 1 and 2 into the masks of lines 5.5, 6.5 and 7.5 (1 = masked, 0 = available). With bit 3 clear, the masks keep their values.
- R3: Control bit 4 clears the 7.5 latch and needs no acknowledge. Bit 5 has no effect. Bit 7 is loaded into the serial output pin only when bit 6 is 1, and otherwise the pin keeps its value.
- R4: A rising edge on line 7.5 sets its latch. The latch stays set while the line is masked. Once the line is unmasked it raises a request even if the input has dropped. The latch clears when a 7.5 request is acknowledged.
- R5: Lines 5.5 and 6.5 are level sensitive. Each one requests only if it is high and unmasked in the cycle the check strobe is sampled.
- R6: The order of precedence is trap, then 7.5, then 6.5, then 5.5, then the non-vectored request. Source codes are none=0, non-vectored=1, 5.5=2, 6.5=3, 7.5=4, trap=5. The vectors are 0x0024 for the trap, 0x003C for 7.5, 0x0034 for 6.5, 0x002C for 5.5 and 0x0000 for the non-vectored request.
- R7: Masks and the global enable have no effect on the trap. The trap input passes through a two-flop synchronizer. A trap is recognized only when a rising edge is followed by a level that is still high at the strobe. After an acknowledge, the trap is not recognized again until the input has gone low and then high.
- R8: Maskable sources and the non-vectored request are taken only while the global enable is 1. The set command raises the enable and the clear command drops it. Acknowledging any source other than the trap drops it. Acknowledging a trap leaves it unchanged.
- R9: The status byte is registered with one cycle of latency. Bits 2:0 are the masks, bit 3 is the global enable, bits 4 and 5 are the raw 5.5 and 6.5 pins, bit 6 is the 7.5 latch and bit 7 is the serial input pin.
- R10: A strobe captures a winner only when no request is held. A held source and vector stay stable until acknowledge, even if a higher source arrives. An acknowledge with nothing held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_in | input | 1 | Non-maskable trap line (asynchronous) |
| lvl55_in | input | 1 | Level-sensitive line 5.5 |
| lvl65_in | input | 1 | Level-sensitive line 6.5 |
| edge75_in | input | 1 | Edge-triggered line 7.5 |
| nv_req_in | input | 1 | Non-vectored request |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| ien_set | input | 1 | Set global enable |
| ien_clr | input | 1 | Clear global enable |
| chk_strobe | input | 1 | Core ready to take an interrupt |
| ack | input | 1 | Acknowledge of held request |
| sin_pin | input | 1 | Serial input pin sample |
| stat_rdata | output | 8 | Status byte |
| sout_pin | output | 1 | Serial output pin register |
| irq_valid | output | 1 | A request is held |
| irq_src | output | 3 | Held source code |
| irq_vector | output | 16 | Held vector |

## Verification
The bench looks for the 7.5 latch losing an edge while the line is masked. A design with that fault would never raise the request once the line is unmasked. It also checks for a fault where bit 4 clears the latch only together with a mask load. It gives the trap a short pulse, which an edge-only detector would wrongly accept. It also holds the trap high after an acknowledge, which a level-only detector would take twice. It checks that bit 3 really gates the mask load, that bit 6 really gates the serial bit, and that bit 5 does nothing. Wrong precedence, or a held request that a later strobe overwrites, shows up as the wrong source code or vector.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int CTL_W  = 8;
  localparam int MASK_N = 3;
  localparam int VEC_W  = 16;

  // control byte fields (positions decoded by the core's software)
  localparam int C_MSE = 3;
  localparam int C_CLR = 4;
  localparam int C_SOE = 6;
  localparam int C_SOD = 7;
  localparam int C_RSV = 5;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_NV   = 3'd1,
    SRC_L55  = 3'd2,
    SRC_L65  = 3'd3,
    SRC_L75  = 3'd4,
    SRC_TRAP = 3'd5
  } src_e;

  function automatic logic [VEC_W-1:0] vec_of(src_e s);
    case (s)
      SRC_TRAP: vec_of = VEC_W'(16'h0024);
      SRC_L75:  vec_of = VEC_W'(16'h003C);
      SRC_L65:  vec_of = VEC_W'(16'h0034);
      SRC_L55:  vec_of = VEC_W'(16'h002C);
      default:  vec_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/vic_mask_regs.sv
module vic_mask_regs
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTL_W-1:0]  wdata,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic              ack_maskable,
  input  logic              ack_l75,
  input  logic              edge75_in,
  output logic [MASK_N-1:0] mask,
  output logic              ien,
  output logic              latch75,
  output logic              sout
);
  logic edge75_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask     <= '1;
      ien      <= 1'b0;
      latch75  <= 1'b0;
      sout     <= 1'b0;
      edge75_d <= 1'b0;
    end else begin
      edge75_d <= edge75_in;
      if (we && wdata[C_MSE]) mask <= wdata[MASK_N-1:0];
      if (we && wdata[C_SOE]) sout <= wdata[C_SOD];
      if (ack_maskable || ien_clr) ien <= 1'b0;
      else if (ien_set)            ien <= 1'b1;
      if ((we && wdata[C_CLR]) || ack_l75)  latch75 <= 1'b0;
      else if (edge75_in && !edge75_d)      latch75 <= 1'b1;
    end
  end

  // R2
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !wdata[C_MSE]) |=> $stable(mask));

  // R3
  latch_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wdata[C_CLR]) |=> !latch75);

  // R3
  ign_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wdata[C_RSV] && !wdata[C_MSE] && !wdata[C_SOE]) |=> ($stable(mask) && $stable(sout)));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latch75 && !(we && wdata[C_CLR]) && !ack_l75) |=> latch75);

  // R8
  ien_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ack_maskable |=> !ien);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_s,
  input  logic              l55,
  input  logic              l65,
  input  logic              nv_req,
  input  logic              latch75,
  input  logic [MASK_N-1:0] mask,
  input  logic              ien,
  input  logic              chk,
  input  logic              ack,
  output logic              irq_valid,
  output src_e              irq_src,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              ack_maskable,
  output logic              ack_l75
);
  logic trap_d, trap_pend, ack_hit;
  src_e win;

  assign ack_hit      = ack && irq_valid;
  assign ack_maskable = ack_hit && (irq_src != SRC_TRAP);
  assign ack_l75      = ack_hit && (irq_src == SRC_L75);

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_d    <= 1'b0;
      trap_pend <= 1'b0;
    end else begin
      trap_d <= trap_s;
      if (!trap_s)                             trap_pend <= 1'b0;
      else if (!trap_d)                        trap_pend <= 1'b1;
      else if (ack_hit && irq_src == SRC_TRAP) trap_pend <= 1'b0;
    end
  end

  always_comb begin
    win = SRC_NONE;
    if (trap_pend && trap_s)           win = SRC_TRAP;
    else if (ien) begin
      if (latch75 && !mask[2])         win = SRC_L75;
      else if (l65 && !mask[1])        win = SRC_L65;
      else if (l55 && !mask[0])        win = SRC_L55;
      else if (nv_req)                 win = SRC_NV;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ack_hit) begin
      irq_valid  <= 1'b0;
      irq_src    <= SRC_NONE;
      irq_vector <= '0;
    end else if (!irq_valid && chk && win != SRC_NONE) begin
      irq_valid  <= 1'b1;
      irq_src    <= win;
      irq_vector <= vec_of(win);
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !ack) |=> (irq_valid && $stable(irq_src) && $stable(irq_vector)));

  // R8
  ien_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_valid) && irq_src != SRC_TRAP) |-> $past(ien));

  // R7
  trap_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_valid) && irq_src == SRC_TRAP) |-> $past(trap_s));
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_in,
  input  logic              lvl55_in,
  input  logic              lvl65_in,
  input  logic              edge75_in,
  input  logic              nv_req_in,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic              chk_strobe,
  input  logic              ack,
  input  logic              sin_pin,
  output logic [CTL_W-1:0]  stat_rdata,
  output logic              sout_pin,
  output logic              irq_valid,
  output logic [2:0]        irq_src,
  output logic [VEC_W-1:0]  irq_vector
);
  logic              trap_s, ien, latch75, ack_maskable, ack_l75;
  logic [MASK_N-1:0] mask;
  src_e              src;

  vic_sync #(.STAGES(SYNC_STAGES), .W(1)) u_trap_sync (
    .clk(clk), .rst(rst), .d(trap_in), .q(trap_s)
  );

  vic_mask_regs u_regs (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .ien_set(ien_set), .ien_clr(ien_clr),
    .ack_maskable(ack_maskable), .ack_l75(ack_l75),
    .edge75_in(edge75_in), .mask(mask), .ien(ien),
    .latch75(latch75), .sout(sout_pin)
  );

  vic_arbiter u_arb (
    .clk(clk), .rst(rst), .trap_s(trap_s), .l55(lvl55_in), .l65(lvl65_in),
    .nv_req(nv_req_in), .latch75(latch75), .mask(mask), .ien(ien),
    .chk(chk_strobe), .ack(ack), .irq_valid(irq_valid), .irq_src(src),
    .irq_vector(irq_vector), .ack_maskable(ack_maskable), .ack_l75(ack_l75)
  );

  assign irq_src = src;

  always_ff @(posedge clk) begin
    if (rst) stat_rdata <= '0;
    else     stat_rdata <= {sin_pin, latch75, lvl65_in, lvl55_in, ien, mask};
  end
endmodule

// File: tb/sim_vic_ctrl.sv
module sim_vic_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic trap_in = 0, lvl55_in = 0, lvl65_in = 0, edge75_in = 0, nv_req_in = 0;
  logic ctl_we = 0, ien_set = 0, ien_clr = 0, chk_strobe = 0, ack = 0, sin_pin = 0;
  logic [7:0]  ctl_wdata = 8'h00;
  logic [7:0]  stat_rdata;
  logic        sout_pin, irq_valid;
  logic [2:0]  irq_src;
  logic [15:0] irq_vector;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  vic_ctrl u0 (
    .clk(clk), .rst(rst), .trap_in(trap_in), .lvl55_in(lvl55_in), .lvl65_in(lvl65_in),
    .edge75_in(edge75_in), .nv_req_in(nv_req_in), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ien_set(ien_set), .ien_clr(ien_clr), .chk_strobe(chk_strobe), .ack(ack),
    .sin_pin(sin_pin), .stat_rdata(stat_rdata), .sout_pin(sout_pin),
    .irq_valid(irq_valid), .irq_src(irq_src), .irq_vector(irq_vector)
  );

  // {control byte, expected masks, expected serial pin}
  localparam logic [11:0] TBL [9] = '{
    {8'h08, 3'b000, 1'b0}, {8'h0F, 3'b111, 1'b0}, {8'h02, 3'b111, 1'b0},
    {8'h0A, 3'b010, 1'b0}, {8'hC0, 3'b010, 1'b1}, {8'h00, 3'b010, 1'b1},
    {8'h40, 3'b010, 1'b0}, {8'h2D, 3'b101, 1'b0}, {8'h88, 3'b000, 1'b0}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    ctl_we = 1; ctl_wdata = v; tick(1); ctl_we = 0; tick(1);
  endtask
  task automatic strobe();
    chk_strobe = 1; tick(1); chk_strobe = 0;
  endtask
  task automatic ack_p();
    ack = 1; tick(1); ack = 0; tick(1);
  endtask
  task automatic ien_on();
    ien_set = 1; tick(1); ien_set = 0; tick(1);
  endtask
  task automatic ien_off();
    ien_clr = 1; tick(1); ien_clr = 0; tick(1);
  endtask
  task automatic pulse75();
    edge75_in = 1; tick(1); edge75_in = 0; tick(1);
  endtask
  task automatic expect_irq(string tag, logic [2:0] s, logic [15:0] v);
    check(tag, {15'd0, irq_valid}, 16'd1);
    check(tag, {13'd0, irq_src}, {13'd0, s});
    check(tag, irq_vector, v);
  endtask
  task automatic expect_none(string tag);
    check(tag, {15'd0, irq_valid}, 16'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <50000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3); rst = 0; tick(1);
    check("R1 status", {8'd0, stat_rdata}, 16'h0007);
    check("R1 sout", {15'd0, sout_pin}, 16'd0);
    expect_none("R1 idle");

    for (int i = 0; i < 9; i++) begin
      wr(TBL[i][11:4]);
      check("R2 masks", {13'd0, stat_rdata[2:0]}, {13'd0, TBL[i][3:1]});
      check("R3 sout", {15'd0, sout_pin}, {15'd0, TBL[i][0]});
    end

    // R9 status layout
    lvl55_in = 1; sin_pin = 1; tick(2);
    check("R9 layout", {8'd0, stat_rdata}, 16'h0090);
    lvl55_in = 0; sin_pin = 0;

    // R8 enable gates, R10 hold
    lvl65_in = 1; tick(1); strobe();
    expect_none("R8 disabled");
    ien_on();
    check("R8 set", {8'd0, stat_rdata}, 16'h0028);
    strobe();
    expect_irq("R6 l65", 3'd3, 16'h0034);
    pulse75(); strobe();
    expect_irq("R10 held", 3'd3, 16'h0034);
    ack_p();
    expect_none("R10 acked");
    check("R8 ack drop", {8'd0, stat_rdata}, 16'h0060);

    // R4 latch beats 6.5, cleared by ack
    ien_on(); strobe();
    expect_irq("R4 l75", 3'd4, 16'h003C);
    ack_p();
    check("R4 latch clr", {8'd0, stat_rdata}, 16'h0020);
    lvl65_in = 0;

    // R4 masked latch held
    wr(8'h0C); pulse75(); ien_on(); strobe();
    expect_none("R4 masked");
    check("R4 held", {8'd0, stat_rdata}, 16'h004C);
    wr(8'h08); strobe();
    expect_irq("R4 unmask", 3'd4, 16'h003C);
    ack_p();

    // R3 bit 4 clears latch
    pulse75(); wr(8'h10);
    check("R3 clr", {8'd0, stat_rdata}, 16'h0000);
    ien_on(); strobe();
    expect_none("R3 no req");

    // R6 lower precedence
    lvl55_in = 1; nv_req_in = 1; tick(1); strobe();
    expect_irq("R6 l55", 3'd2, 16'h002C);
    ack_p(); ien_on(); lvl55_in = 0; tick(1); strobe();
    expect_irq("R6 nv", 3'd1, 16'h0000);
    ack_p(); nv_req_in = 0;
    check("R8 nv drop", {8'd0, stat_rdata}, 16'h0000);

    // R5 level gone before strobe
    ien_on(); lvl55_in = 1; tick(2); lvl55_in = 0; tick(1); strobe();
    expect_none("R5 level");
    ack_p();
    check("R10 stray ack", {8'd0, stat_rdata}, 16'h0008);

    // R7 trap
    wr(8'h0F);
    trap_in = 1; tick(4); strobe();
    expect_irq("R7 trap", 3'd5, 16'h0024);
    ack_p();
    check("R8 trap keeps ien", {8'd0, stat_rdata}, 16'h000F);
    ien_off(); strobe();
    expect_none("R7 no retrigger");
    trap_in = 0; tick(3); trap_in = 1; tick(4); strobe();
    expect_irq("R7 rearm", 3'd5, 16'h0024);
    ack_p(); trap_in = 0; tick(3);
    trap_in = 1; tick(1); trap_in = 0; tick(6); strobe();
    expect_none("R7 short pulse");

    // R1 mid-run reset
    wr(8'hC0); rst = 1; tick(2); rst = 0; tick(1);
    check("R1 rerst", {8'd0, stat_rdata}, 16'h0007);
    check("R1 sout rerst", {15'd0, sout_pin}, 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule